// File: doc/BRIEF.md
# Dual-Core Lockstep Divergence Guard

This block watches the output buses of two identical cores that run the same program in lockstep and compares them on every clock. It only detects disagreement: it never votes, never corrects data and never picks a winner. When the buses differ, it stalls both cores together and drives a restore sequence that returns both of them to the last checkpoint known to be good. While that sequence runs, no work progresses.

The block also sets the pace of checkpoints. After a programmable number of clean run cycles, it stalls the pair and pulses a capture request to external checkpoint storage, then waits for that storage to report completion. A checkpoint becomes the restore target only if no divergence was seen between the request and the completion. After a restore, a short verification window with the cores still stalled must pass clean. Each failed window counts as a failed rollback, and a set number of consecutive failures ends in a terminal fatal state. A divergence seen before any checkpoint has been committed also goes straight to that fatal state, because there is nothing safe to return to.

Top module: `lockstep_guard`

## Requirements
- R1: While reset is held and on the first cycle after it, `core_stall`, `ckpt_req`, `restore_req`, `fatal_err` and `ckpt_valid` are 0 and `mismatch_count` is 0.
- R2: Every clock edge at which `core_a_bus` differs from `core_b_bus` in any bit adds one to `mismatch_count`, in every state. The count saturates at its all-ones value.
- R3: With `ckpt_period` = P > 0, the edge that ends P consecutive clean run cycles starts a capture. `ckpt_req` goes high for exactly one cycle and `core_stall` stays high until `ckpt_done`. With P = 0, no capture ever starts.
- R4: A `ckpt_done` pulse with no divergence since the request sets `ckpt_valid` and returns to run, so `core_stall` is 0 in the next cycle.
- R5: If a divergence was seen between request and `ckpt_done`, `ckpt_valid` keeps its previous value. On `ckpt_done` the block starts a rollback if a checkpoint is already valid and goes fatal otherwise. Once set, `ckpt_valid` never clears before reset.
- R6: A divergence during run with a valid checkpoint makes `core_stall` 1 and `restore_req` a one-cycle pulse in the next cycle.
- R7: After `restore_done`, `core_stall` stays 1 for a window of VERIFY_CYC clean cycles and then returns to 0.
- R8: A divergence inside the verification window issues a new one-cycle `restore_req` in the next cycle, with the stall still held.
- R9: MAX_FAILS consecutive failed verification windows raise `fatal_err`. A clean window resets the failure tally.
- R10: A divergence during run before any checkpoint has been committed raises `fatal_err` in the next cycle.
- R11: `fatal_err` stays set until reset. While it is set, `core_stall` is 1 and neither strobe is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| core_a_bus | input | DATA_W | Output bus of the first core |
| core_b_bus | input | DATA_W | Output bus of the second core |
| ckpt_period | input | PERIOD_W | Clean run cycles between captures; 0 disables capture |
| ckpt_done | input | 1 | Checkpoint storage has finished a capture |
| restore_done | input | 1 | Checkpoint storage has finished reloading both cores |
| core_stall | output | 1 | Freezes both cores |
| ckpt_req | output | 1 | One-cycle capture request |
| restore_req | output | 1 | One-cycle restore request |
| ckpt_valid | output | 1 | A committed checkpoint exists |
| fatal_err | output | 1 | Unrecoverable divergence |
| mismatch_count | output | CNT_W | Saturating count of divergent cycles |

## Verification
The comparison is tried with buses that differ only in their lowest bit, only in their top bit and in every bit. A comparator that checks only part of the word misses one of these, and the first two also tell a bitwise compare from an arithmetic one. Divergences are placed in each state: during run with and without a committed checkpoint, inside a capture, while the restore is pending and inside the verification window. Together these separate the rollback path from the fatal path and show whether a dirty capture is wrongly committed. A run with one failed window followed by a clean one shows whether the failure tally is cleared. A long divergence shows whether the counter saturates.

// File: rtl/lsg_pkg.sv
// Shared definitions for the lockstep guard.
package lsg_pkg;
    // Controller states.
    typedef enum logic [2:0] {
        ST_RUN      = 3'd0,
        ST_CKPT     = 3'd1,
        ST_HOLD     = 3'd2,
        ST_ROLLBACK = 3'd3,
        ST_FATAL    = 3'd4
    } guard_state_t;
endpackage

// File: rtl/lsg_compare.sv
// Compares the two core buses every cycle and keeps a saturating count of
// the cycles in which they differed.
// Assumes: both buses are sampled on the same clock as this block.
module lsg_compare #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] bus_a,
    input  logic [DATA_W-1:0] bus_b,
    output logic              diverge,
    output logic [CNT_W-1:0]  div_count
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    // Divergence detect: any differing bit.
    always_comb diverge = |(bus_a ^ bus_b);

    // Saturating count of divergent cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)
            div_count <= '0;
        else if (diverge && div_count != CNT_MAX)
            div_count <= div_count + 1'b1;
    end
endmodule

// File: rtl/lsg_ckpt_timer.sv
// Counts clean run cycles and flags when a checkpoint is due.
// Assumes: run_en is low in every non-run state, which restarts the count.
// A period of zero disables checkpoints; lowering the period mid-count
// makes the next checkpoint due at once.
module lsg_ckpt_timer #(
    parameter int PERIOD_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run_en,
    input  logic [PERIOD_W-1:0] period,
    output logic                due
);
    logic [PERIOD_W-1:0] run_cnt;

    // Due flag: count has reached the last cycle of the period.
    always_comb due = run_en && (period != '0) && (run_cnt >= period - 1'b1);

    // Run-cycle counter, restarted outside run and at each due point.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_en || due)
            run_cnt <= '0;
        else
            run_cnt <= run_cnt + 1'b1;
    end
endmodule

// File: rtl/lsg_fsm.sv
// Controller for the checkpoint and rollback sequence. It never chooses a
// correct core; every divergence leads either to a restore of both cores
// or to the fatal state.
// Assumes: VERIFY_CYC >= 1 and MAX_FAILS >= 1; ckpt_done and restore_done
// are only meaningful while the matching request is outstanding.
module lsg_fsm
    import lsg_pkg::*;
#(
    parameter int VERIFY_CYC = 4,
    parameter int MAX_FAILS  = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic diverge,
    input  logic ckpt_due,
    input  logic ckpt_done,
    input  logic restore_done,
    output logic in_run,
    output logic stall,
    output logic ckpt_strobe,
    output logic restore_strobe,
    output logic have_ckpt,
    output logic fatal
);
    localparam int VW = $clog2(VERIFY_CYC + 1);
    localparam int FW = $clog2(MAX_FAILS + 1);
    localparam logic [VW-1:0] V_LAST = VW'(VERIFY_CYC - 1);
    localparam logic [FW-1:0] F_LAST = FW'(MAX_FAILS - 1);

    guard_state_t st, nxt;
    logic          dirty;
    logic [VW-1:0] vcnt;
    logic [FW-1:0] fails;

    // Next-state selection.
    always_comb begin
        nxt = st;
        unique case (st)
            ST_RUN: begin
                if (diverge)       nxt = have_ckpt ? ST_ROLLBACK : ST_FATAL;
                else if (ckpt_due) nxt = ST_CKPT;
            end
            ST_CKPT: begin
                if (ckpt_done) begin
                    if (dirty || diverge) nxt = have_ckpt ? ST_ROLLBACK : ST_FATAL;
                    else                  nxt = ST_RUN;
                end
            end
            ST_ROLLBACK: begin
                if (restore_done) nxt = ST_HOLD;
            end
            ST_HOLD: begin
                if (diverge)             nxt = (fails == F_LAST) ? ST_FATAL : ST_ROLLBACK;
                else if (vcnt == V_LAST) nxt = ST_RUN;
            end
            default: nxt = ST_FATAL;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_RUN;
        else        st <= nxt;
    end

    // Request strobes, one cycle on entry to capture or restore.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ckpt_strobe    <= 1'b0;
            restore_strobe <= 1'b0;
        end else begin
            ckpt_strobe    <= (nxt == ST_CKPT) && (st != ST_CKPT);
            restore_strobe <= (nxt == ST_ROLLBACK) && (st != ST_ROLLBACK);
        end
    end

    // Dirty flag: a divergence seen since the capture request.
    always_ff @(posedge clk) begin
        if (!rst_n || st != ST_CKPT) dirty <= 1'b0;
        else if (diverge)            dirty <= 1'b1;
    end

    // Committed-checkpoint flag, set only by a clean capture.
    always_ff @(posedge clk) begin
        if (!rst_n)
            have_ckpt <= 1'b0;
        else if (st == ST_CKPT && ckpt_done && !dirty && !diverge)
            have_ckpt <= 1'b1;
    end

    // Verification window counter.
    always_ff @(posedge clk) begin
        if (!rst_n || st != ST_HOLD) vcnt <= '0;
        else if (!diverge)           vcnt <= vcnt + 1'b1;
    end

    // Consecutive failed-rollback tally.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fails <= '0;
        else if (st == ST_HOLD) begin
            if (diverge)             fails <= fails + 1'b1;
            else if (vcnt == V_LAST) fails <= '0;
        end
    end

    // Decoded state outputs.
    always_comb begin
        in_run = (st == ST_RUN);
        stall  = (st != ST_RUN);
        fatal  = (st == ST_FATAL);
    end
endmodule

// File: rtl/lockstep_guard.sv
// Top of the lockstep guard: comparator, checkpoint timer and controller.
// Assumes: the two cores and the checkpoint storage sit outside and obey
// core_stall, ckpt_req and restore_req.
module lockstep_guard #(
    parameter int DATA_W     = 32,
    parameter int PERIOD_W   = 16,
    parameter int CNT_W      = 8,
    parameter int VERIFY_CYC = 4,
    parameter int MAX_FAILS  = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [DATA_W-1:0]   core_a_bus,
    input  logic [DATA_W-1:0]   core_b_bus,
    input  logic [PERIOD_W-1:0] ckpt_period,
    input  logic                ckpt_done,
    input  logic                restore_done,
    output logic                core_stall,
    output logic                ckpt_req,
    output logic                restore_req,
    output logic                ckpt_valid,
    output logic                fatal_err,
    output logic [CNT_W-1:0]    mismatch_count
);
    logic diverge;
    logic in_run;
    logic due;

    lsg_compare #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_cmp (
        .clk(clk), .rst_n(rst_n), .bus_a(core_a_bus), .bus_b(core_b_bus),
        .diverge(diverge), .div_count(mismatch_count)
    );

    lsg_ckpt_timer #(.PERIOD_W(PERIOD_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .run_en(in_run), .period(ckpt_period),
        .due(due)
    );

    lsg_fsm #(.VERIFY_CYC(VERIFY_CYC), .MAX_FAILS(MAX_FAILS)) u_fsm (
        .clk(clk), .rst_n(rst_n), .diverge(diverge), .ckpt_due(due),
        .ckpt_done(ckpt_done), .restore_done(restore_done), .in_run(in_run),
        .stall(core_stall), .ckpt_strobe(ckpt_req), .restore_strobe(restore_req),
        .have_ckpt(ckpt_valid), .fatal(fatal_err)
    );
endmodule

// File: rtl/lockstep_guard_checker.sv
// Temporal checks on the guard's ports, bound to every instance of the top.
module lockstep_guard_checker #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] core_a_bus,
    input logic [DATA_W-1:0] core_b_bus,
    input logic              core_stall,
    input logic              ckpt_req,
    input logic              restore_req,
    input logic              ckpt_valid,
    input logic              fatal_err,
    input logic [CNT_W-1:0]  mismatch_count
);
    logic mis;
    always_comb mis = (core_a_bus != core_b_bus);

    p_count_mono_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> mismatch_count >= $past(mismatch_count));
    p_ckpt_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ckpt_req |=> !ckpt_req);
    p_ckpt_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ckpt_req |-> core_stall);
    p_valid_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ckpt_valid |=> ckpt_valid);
    p_restore_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        restore_req |=> !restore_req);
    p_run_rollback_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!core_stall && mis && ckpt_valid) |=> (restore_req && core_stall));
    p_early_fatal_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!core_stall && mis && !ckpt_valid) |=> fatal_err);
    p_fatal_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        fatal_err |=> fatal_err);
    p_fatal_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        fatal_err |-> (core_stall && !restore_req && !ckpt_req));
endmodule

bind lockstep_guard lockstep_guard_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .core_a_bus(core_a_bus), .core_b_bus(core_b_bus),
    .core_stall(core_stall), .ckpt_req(ckpt_req), .restore_req(restore_req),
    .ckpt_valid(ckpt_valid), .fatal_err(fatal_err), .mismatch_count(mismatch_count)
);

// File: tb/lockstep_guard_tb.sv
// Directed bench for the lockstep guard; one task per scenario.
module lockstep_guard_tb;
    localparam int DW = 16, PW = 8, CW = 4, VC = 3, MF = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] a_bus = '0, b_bus = '0;
    logic [PW-1:0] period = '0;
    logic          done_c = 1'b0, done_r = 1'b0;
    logic          stall, creq, rreq, valid, fatal;
    logic [CW-1:0] cnt;
    int checks = 0, fails = 0;
    bit finished = 0;

    always #10 clk = ~clk;  // 50 MHz

    lockstep_guard #(.DATA_W(DW), .PERIOD_W(PW), .CNT_W(CW),
                     .VERIFY_CYC(VC), .MAX_FAILS(MF)) u_dut (
        .clk(clk), .rst_n(rst_n), .core_a_bus(a_bus), .core_b_bus(b_bus),
        .ckpt_period(period), .ckpt_done(done_c), .restore_done(done_r),
        .core_stall(stall), .ckpt_req(creq), .restore_req(rreq),
        .ckpt_valid(valid), .fatal_err(fatal), .mismatch_count(cnt)
    );

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(logic [PW-1:0] p);
        rst_n = 1'b0; a_bus = 16'h3C3C; b_bus = 16'h3C3C;
        done_c = 1'b0; done_r = 1'b0; period = p;
        step(3);
        rst_n = 1'b1;
    endtask

    // Reset, then commit the first checkpoint with period 4.
    task automatic commit_first();
        do_reset(8'd4);
        step(4);
        done_c = 1'b1; step(1); done_c = 1'b0;
        period = 8'd200;
    endtask

    // One-cycle divergence with the given b value.
    task automatic diverge_once(logic [DW-1:0] bv);
        b_bus = bv; step(1); b_bus = a_bus;
    endtask

    task automatic t_reset();
        do_reset(8'd0);
        check("R1", "stall", stall, 0); check("R1", "ckpt_req", creq, 0);
        check("R1", "restore_req", rreq, 0); check("R1", "fatal", fatal, 0);
        check("R1", "valid", valid, 0); check("R1", "count", cnt, 0);
        step(1);
        check("R1", "stall after release", stall, 0);
    endtask

    task automatic t_early_fatal();
        do_reset(8'd0);
        step(2);
        diverge_once(16'h3C3D);  // lowest bit differs
        check("R10", "fatal", fatal, 1);
        check("R2", "count", cnt, 1);
        step(6);
        check("R11", "fatal held", fatal, 1);
        check("R11", "stall", stall, 1);
        check("R11", "restore_req", rreq, 0);
    endtask

    task automatic t_checkpoint();
        do_reset(8'd4);
        step(3);
        check("R3", "no req before period", creq, 0);
        check("R3", "no stall before period", stall, 0);
        step(1);
        check("R3", "req at period", creq, 1);
        check("R3", "stall in capture", stall, 1);
        step(1);
        check("R3", "req one cycle", creq, 0);
        check("R3", "stall until done", stall, 1);
        done_c = 1'b1; step(1); done_c = 1'b0;
        check("R4", "valid", valid, 1);
        check("R4", "stall cleared", stall, 0);
        do_reset(8'd0);
        begin
            int seen = 0;
            for (int i = 0; i < 20; i++) begin step(1); seen += creq; end
            check("R3", "period 0 gives no capture", seen, 0);
        end
    endtask

    task automatic t_rollback();
        commit_first();
        step(2);
        diverge_once(16'hBC3C);  // top bit differs
        check("R6", "stall", stall, 1);
        check("R6", "restore_req", rreq, 1);
        step(1);
        check("R6", "restore one cycle", rreq, 0);
        done_r = 1'b1; step(1); done_r = 1'b0;
        step(2);
        check("R7", "stall in window", stall, 1);
        step(1);
        check("R7", "run after window", stall, 0);
        check("R7", "not fatal", fatal, 0);
    endtask

    task automatic t_retry_fatal();
        commit_first();
        diverge_once(16'hC3C3);  // every bit differs
        step(1);
        done_r = 1'b1; step(1); done_r = 1'b0;
        diverge_once(16'hC3C3);
        check("R8", "new restore_req", rreq, 1);
        check("R8", "stall held", stall, 1);
        step(1);
        done_r = 1'b1; step(1); done_r = 1'b0;
        diverge_once(16'hC3C3);
        check("R9", "fatal after max fails", fatal, 1);
        check("R9", "no restore", rreq, 0);
        // One failure, clean window, then one failure must not be fatal.
        commit_first();
        diverge_once(16'h3C3D); step(1);
        done_r = 1'b1; step(1); done_r = 1'b0;
        diverge_once(16'h3C3D); step(1);
        done_r = 1'b1; step(1); done_r = 1'b0;
        step(VC);
        check("R9", "back to run", stall, 0);
        diverge_once(16'h3C3D); step(1);
        done_r = 1'b1; step(1); done_r = 1'b0;
        diverge_once(16'h3C3D);
        check("R9", "tally cleared", fatal, 0);
        check("R9", "retry issued", rreq, 1);
    endtask

    task automatic t_dirty_capture();
        commit_first();
        period = 8'd3;
        step(3);
        check("R3", "second capture", creq, 1);
        diverge_once(16'h3C3D);
        step(1);
        done_c = 1'b1; step(1); done_c = 1'b0;
        check("R5", "rollback on dirty", rreq, 1);
        check("R5", "valid kept", valid, 1);
        check("R5", "not fatal", fatal, 0);
        do_reset(8'd4);
        step(4);
        diverge_once(16'h3C3D);
        done_c = 1'b1; step(1); done_c = 1'b0;
        check("R5", "fatal on dirty first", fatal, 1);
        check("R5", "valid not set", valid, 0);
    endtask

    task automatic t_saturate();
        do_reset(8'd0);
        b_bus = 16'h0000;
        step(20);
        b_bus = a_bus;
        check("R2", "saturated count", cnt, 15);
    endtask

    initial begin
        t_reset();
        t_early_fatal();
        t_checkpoint();
        t_rollback();
        t_retry_fatal();
        t_dirty_capture();
        t_saturate();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule